// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures a target FPGA through its one-bit slave serial port. A start request makes it pull the active-low program line, wait for the target's active-low init line to go low, release program, and wait for init to come back high. It then takes configuration bytes from an upstream byte stream over a valid/ready handshake. Each byte is sent most significant bit first, one bit per configuration clock period, with the data line set while the configuration clock is low and captured by the target on the rising edge.

Before it accepts each byte, the loader checks whether the target reports a CRC error: init low while done is still low. Once the byte marked last has been sent, it holds the data line high and keeps pulsing the configuration clock until the target raises done. Every wait phase has its own cycle-count timeout. A load always ends with a one-cycle finish pulse and a 2-bit result code. The configuration clock half-period and the timeout are parameters in system clock cycles. The default timeout is 10 ms at 50 MHz. The init and done inputs are expected to be synchronous to the system clock.

Top module: `cfg_serial_loader`

## Requirements
- R1: After start, prog_n_o is held low, with cclk_o idle high, until init_n_i is sampled low. If init_n_i stays high for TIMEOUT_CYCLES cycles, the load ends with result 01 (timeout), and prog_n_o has been low for exactly TIMEOUT_CYCLES cycles.
- R2: After prog_n_o is released, no configuration clock edge occurs until init_n_i is sampled high. If init_n_i stays low for TIMEOUT_CYCLES cycles, the load ends with result 01.
- R3: Bytes are taken only when in_valid_i and in_ready_o are both high. Each byte produces exactly 8 rising edges of cclk_o, and din_o carries bit 7 first and bit 0 last.
- R4: Each low phase of cclk_o lasts HALF_CYCLES system cycles. din_o changes only while cclk_o is low, both in the cycle before the change and in the cycle of the change.
- R5: Before each byte, if init_n_i is low while done_i is low, the load ends with result 10 (CRC error), and no further byte is accepted.
- R6: After the byte flagged by in_last_i, din_o is high on every rising edge of cclk_o. done_i is sampled at the end of each clock period, and the first period that ends with done_i high ends the load with result 00 (success). If done_i stays low for TIMEOUT_CYCLES cycles, the result is 01.
- R7: Every load ends with exactly one one-cycle pulse of fin_o. In that cycle status_o already holds the result, one of 00, 01 or 10. status_o keeps that value until the next accepted start, and prog_n_o is high from the finish pulse onward.
- R8: A start_i pulse while busy_o is high is ignored: the load in progress continues and program is not pulsed again.
- R9: After reset, prog_n_o, cclk_o and status_o are 1, 1 and 00, and busy_o, fin_o and in_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a configuration load (ignored while busy) |
| in_data_i | input | 8 | Configuration byte from the stream |
| in_last_i | input | 1 | Marks the final byte of the stream |
| in_valid_i | input | 1 | Stream byte is valid |
| in_ready_o | output | 1 | Loader accepts a byte this cycle |
| prog_n_o | output | 1 | Program line to the target, active low |
| init_n_i | input | 1 | Init line from the target, active low |
| done_i | input | 1 | Done line from the target |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data to the target |
| busy_o | output | 1 | A load is in progress |
| fin_o | output | 1 | One-cycle pulse when a load ends |
| status_o | output | 2 | Result: 00 success, 01 timeout, 10 CRC error |

## Verification
A corrupted bit counter or shift register appears at the target pins within one byte: the bench rebuilds each byte from din_o sampled at cclk_o rising edges, and a bad counter gives the wrong number of edges. A phase counter that drifts shows up in the same period as a low phase of the wrong length, or as din_o moving while cclk_o is high. A state register stuck in a wait phase shows up after exactly TIMEOUT_CYCLES cycles as an unexpected timeout code, or as a second program pulse. A wrong done or CRC decision shows up as a mismatch in the number of tail clock edges or of accepted bytes.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_REL,
        ST_FETCH,
        ST_SHIFT,
        ST_TAIL,
        ST_FIN
    } cfgl_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_TIMEOUT = 2'b01,
        RES_CRC     = 2'b10
    } cfgl_result_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } cfgl_beat_t;

    // Target signals a CRC fault: init active while done not yet reached
    function automatic logic crc_fault(input logic init_n, input logic done);
        return !init_n && !done;
    endfunction

    // States bounded by the wait timer
    function automatic logic is_wait(input cfgl_state_e s);
        return (s == ST_PROG) || (s == ST_REL) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/cfgl_cclk_gen.sv
module cfgl_cclk_gen #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic cclk,
    output logic load_tick,
    output logic end_tick
);
    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned PW     = $clog2(PERIOD);

    logic [PW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pc_q <= '0;
        end else if (pc_q == PW'(PERIOD - 1)) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PW'(1);
        end
    end

    // Low for the first HALF cycles of each period, idle high when stopped
    assign cclk      = !(run && (pc_q < PW'(HALF)));
    assign load_tick = run && (pc_q == '0);
    assign end_tick  = run && (pc_q == PW'(PERIOD - 1));

endmodule

// File: rtl/cfgl_wait_timer.sv
module cfgl_wait_timer #(
    parameter int unsigned LIMIT = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && !expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = en && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter
    import cfgl_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  cfgl_beat_t beat_i,
    input  logic       shift_i,
    output logic       msb_o,
    output logic       last_o,
    output logic       byte_end_o
);
    localparam int unsigned BW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic [BW-1:0] bit_q;
    logic          last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            bit_q  <= '0;
            last_q <= 1'b0;
        end else if (load_i) begin
            sr_q   <= beat_i.data;
            bit_q  <= '0;
            last_q <= beat_i.last;
        end else if (shift_i) begin
            sr_q   <= {sr_q[W-2:0], 1'b0};
            bit_q  <= bit_q + BW'(1);
        end
    end

    assign msb_o      = sr_q[W-1];
    assign last_o     = last_q;
    assign byte_end_o = shift_i && (bit_q == BW'(W - 1));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int unsigned HALF_CYCLES    = 4,
    parameter int unsigned TIMEOUT_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] in_data_i,
    input  logic              in_last_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              prog_n_o,
    input  logic              init_n_i,
    input  logic              done_i,
    output logic              cclk_o,
    output logic              din_o,
    output logic              busy_o,
    output logic              fin_o,
    output logic [1:0]        status_o
);
    cfgl_state_e  st_q, st_d;
    cfgl_result_e res_q, res_d;
    logic         take;
    logic         run;
    logic         load_tick, end_tick;
    logic         tmo;
    logic         msb, last_byte, byte_end;
    logic         din_q;
    cfgl_beat_t   beat;

    assign run  = (st_q == ST_SHIFT) || (st_q == ST_TAIL);
    assign beat = '{data: in_data_i, last: in_last_i};

    cfgl_cclk_gen #(
        .HALF(HALF_CYCLES)
    ) u_cclk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .cclk      (cclk_o),
        .load_tick (load_tick),
        .end_tick  (end_tick)
    );

    cfgl_wait_timer #(
        .LIMIT(TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (st_d != st_q),
        .en      (is_wait(st_q)),
        .expired (tmo)
    );

    cfgl_shifter #(
        .W(BYTE_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load_i     (take),
        .beat_i     (beat),
        .shift_i    (end_tick && (st_q == ST_SHIFT)),
        .msb_o      (msb),
        .last_o     (last_byte),
        .byte_end_o (byte_end)
    );

    always_comb begin
        st_d  = st_q;
        res_d = res_q;
        take  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d  = ST_PROG;
                    res_d = RES_OK;
                end
            end
            ST_PROG: begin
                if (!init_n_i) begin
                    st_d = ST_REL;
                end else if (tmo) begin
                    st_d  = ST_FIN;
                    res_d = RES_TIMEOUT;
                end
            end
            ST_REL: begin
                if (init_n_i) begin
                    st_d = ST_FETCH;
                end else if (tmo) begin
                    st_d  = ST_FIN;
                    res_d = RES_TIMEOUT;
                end
            end
            ST_FETCH: begin
                if (crc_fault(init_n_i, done_i)) begin
                    st_d  = ST_FIN;
                    res_d = RES_CRC;
                end else if (in_valid_i) begin
                    take = 1'b1;
                    st_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (byte_end) begin
                    st_d = last_byte ? ST_TAIL : ST_FETCH;
                end
            end
            ST_TAIL: begin
                if (end_tick && done_i) begin
                    st_d  = ST_FIN;
                    res_d = RES_OK;
                end else if (tmo) begin
                    st_d  = ST_FIN;
                    res_d = RES_TIMEOUT;
                end
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            res_q <= RES_OK;
            din_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            res_q <= res_d;
            // Data moves one cycle into the low phase; high during the tail
            if (load_tick) begin
                din_q <= (st_q == ST_TAIL) ? 1'b1 : msb;
            end
        end
    end

    assign din_o      = din_q;
    assign prog_n_o   = (st_q != ST_PROG);
    assign in_ready_o = (st_q == ST_FETCH) && !crc_fault(init_n_i, done_i);
    assign busy_o     = (st_q != ST_IDLE) && (st_q != ST_FIN);
    assign fin_o      = (st_q == ST_FIN);
    assign status_o   = res_q;

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       in_ready_o,
    input logic       prog_n_o,
    input logic       cclk_o,
    input logic       din_o,
    input logic       busy_o,
    input logic       fin_o,
    input logic [1:0] status_o
);
    p_no_clock_in_prog_r1: assert property (@(posedge clk) disable iff (rst)
        !prog_n_o |-> cclk_o);

    p_ready_loading_r3: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |-> (busy_o && prog_n_o));

    p_din_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(din_o) |-> (!cclk_o && !$past(cclk_o)));

    p_fin_single_r7: assert property (@(posedge clk) disable iff (rst)
        fin_o |=> !fin_o);

    p_fin_released_r7: assert property (@(posedge clk) disable iff (rst)
        fin_o |-> (prog_n_o && !busy_o));

    p_status_code_r7: assert property (@(posedge clk) disable iff (rst)
        fin_o |-> (status_o != 2'b11));

    p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(status_o));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || fin_o));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .in_ready_o (in_ready_o),
    .prog_n_o   (prog_n_o),
    .cclk_o     (cclk_o),
    .din_o      (din_o),
    .busy_o     (busy_o),
    .fin_o      (fin_o),
    .status_o   (status_o)
);

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
    localparam int HALF = 2;
    localparam int TMO  = 200;
    localparam int NSC  = 6;

    localparam logic [7:0] PAYLOAD [8] = '{8'hA5, 8'h3C, 8'hFF, 8'h00,
                                           8'h81, 8'h7E, 8'h12, 8'hC9};
    // {bytes, init-low delay, init-high delay, done after N tail edges, crc at byte, result}
    // 255 = never, crc 15 = none
    localparam logic [35:0] SCEN [NSC] = '{
        {4'd8, 8'd5,   8'd7,   8'd3,   4'hF, 4'd0},
        {4'd1, 8'd1,   8'd1,   8'd1,   4'hF, 4'd0},
        {4'd2, 8'd255, 8'd3,   8'd1,   4'hF, 4'd1},
        {4'd2, 8'd4,   8'd255, 8'd1,   4'hF, 4'd1},
        {4'd2, 8'd2,   8'd2,   8'd255, 4'hF, 4'd1},
        {4'd6, 8'd3,   8'd3,   8'd2,   4'd3, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_last_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic       in_ready_o;
    logic       prog_n_o;
    logic       init_n_i = 1'b1;
    logic       done_i = 1'b0;
    logic       cclk_o;
    logic       din_o;
    logic       busy_o;
    logic       fin_o;
    logic [1:0] status_o;

    int checks = 0;
    int errors = 0;

    // target / source model state
    int cur_n, cur_init, cur_rel, cur_done, cur_crc;
    int phase, pcnt, rcnt, rx_bits, tail_edges, tail_bad, din_bad;
    int low_run, low_bad, src_idx, prog_falls;
    logic [7:0] rx_shift;
    logic [7:0] rx_byte [8];
    logic m_prev_cclk, m_prev_din, m_prev_prog;
    bit   src_on, acc_pend;

    always #10 clk = ~clk;

    cfg_serial_loader #(
        .HALF_CYCLES   (HALF),
        .TIMEOUT_CYCLES(TMO)
    ) u_cfg_serial_loader (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .in_data_i  (in_data_i),
        .in_last_i  (in_last_i),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .prog_n_o   (prog_n_o),
        .init_n_i   (init_n_i),
        .done_i     (done_i),
        .cclk_o     (cclk_o),
        .din_o      (din_o),
        .busy_o     (busy_o),
        .fin_o      (fin_o),
        .status_o   (status_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_src();
        in_valid_i = src_on && (src_idx < cur_n);
        in_data_i  = (src_idx < 8) ? PAYLOAD[src_idx] : 8'h00;
        in_last_i  = (src_idx == cur_n - 1);
    endtask

    task automatic model_reset();
        phase = 0; pcnt = 0; rcnt = 0; rx_bits = 0; tail_edges = 0;
        tail_bad = 0; din_bad = 0; low_run = 0; low_bad = 0;
        src_idx = 0; prog_falls = 0; rx_shift = 8'h00;
        for (int i = 0; i < 8; i++) rx_byte[i] = 8'h00;
        m_prev_cclk = cclk_o; m_prev_din = din_o; m_prev_prog = prog_n_o;
        acc_pend = 1'b0;
        init_n_i = 1'b1; done_i = 1'b0;
        drive_src();
    endtask

    task automatic model_step();
        if (acc_pend) src_idx++;
        if (!cclk_o) low_run++;
        if (cclk_o && !m_prev_cclk) begin
            if (low_run != HALF) low_bad++;
            low_run = 0;
            if (rx_bits < 8 * cur_n) begin
                rx_shift = {rx_shift[6:0], din_o};
                rx_bits++;
                if (rx_bits % 8 == 0) rx_byte[rx_bits / 8 - 1] = rx_shift;
            end else begin
                tail_edges++;
                if (!din_o) tail_bad++;
                if (cur_done != 255 && tail_edges >= cur_done) done_i = 1'b1;
            end
        end
        if ((din_o !== m_prev_din) && (cclk_o || m_prev_cclk)) din_bad++;
        if (!prog_n_o && m_prev_prog) prog_falls++;
        m_prev_cclk = cclk_o;
        m_prev_din  = din_o;
        m_prev_prog = prog_n_o;
        if (!prog_n_o) begin
            phase = 1;
            pcnt++;
            done_i = 1'b0;
            if (cur_init != 255 && pcnt >= cur_init) init_n_i = 1'b0;
        end else if (phase == 1) begin
            phase = 2;
            rcnt  = 0;
        end
        if (phase == 2) begin
            rcnt++;
            if (cur_rel != 255 && rcnt >= cur_rel && !init_n_i) begin
                init_n_i = 1'b1;
                phase    = 3;
            end
        end
        if (phase == 3 && cur_crc != 15 && rx_bits == 8 * cur_crc) init_n_i = 1'b0;
        drive_src();
    endtask

    initial begin
        cur_n = 0; cur_init = 255; cur_rel = 255; cur_done = 255; cur_crc = 15;
        src_on = 1'b0;
        forever begin
            @(negedge clk);
            model_step();
            #2;
            acc_pend = in_valid_i && in_ready_o;
        end
    end

    task automatic tick();
        @(negedge clk);
        #4;
    endtask

    task automatic run_scen(input int s, input bit restart);
        int exp_res, exp_rx, fins, waited;
        string tag;
        logic [1:0] res_seen;
        cur_n    = int'(SCEN[s][35:32]);
        cur_init = int'(SCEN[s][31:24]);
        cur_rel  = int'(SCEN[s][23:16]);
        cur_done = int'(SCEN[s][15:8]);
        cur_crc  = int'(SCEN[s][7:4]);
        exp_res  = int'(SCEN[s][3:0]);
        if (cur_crc != 15) begin exp_rx = cur_crc; tag = "R5"; end
        else if (cur_init == 255) begin exp_rx = 0; tag = "R1"; end
        else if (cur_rel == 255) begin exp_rx = 0; tag = "R2"; end
        else begin exp_rx = cur_n; tag = "R6"; end
        if (restart) tag = "R8";
        src_on = 1'b1;
        model_reset();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        fins = 0;
        waited = 0;
        while (!fin_o && waited < 3000) begin
            tick();
            waited++;
            if (restart && waited == 60) start_i = 1'b1;
            if (restart && waited == 61) start_i = 1'b0;
        end
        chk(fin_o, "R7 finish reached", waited, 3000);
        res_seen = status_o;
        chk(status_o == 2'(exp_res), tag, int'(status_o), exp_res);
        for (int k = 0; k < 4; k++) begin
            if (fin_o) fins++;
            tick();
        end
        chk(fins == 1, "R7 single fin pulse", fins, 1);
        chk(status_o == res_seen, "R7 status held", int'(status_o), int'(res_seen));
        chk(prog_n_o == 1'b1, "R7 program released", int'(prog_n_o), 1);
        chk(rx_bits == 8 * exp_rx, "R3 bits received", rx_bits, 8 * exp_rx);
        for (int i = 0; i < exp_rx; i++)
            chk(rx_byte[i] == PAYLOAD[i], "R3 byte msb first", int'(rx_byte[i]), int'(PAYLOAD[i]));
        chk(din_bad == 0, "R4 din moved while cclk high", din_bad, 0);
        if (exp_res == 0) begin
            chk(low_bad == 0, "R4 low phase length", low_bad, 0);
            chk(tail_bad == 0, "R6 din high in tail", tail_bad, 0);
            chk(tail_edges == cur_done, "R6 tail edges", tail_edges, cur_done);
        end
        if (cur_init == 255)
            chk(pcnt == TMO, "R1 program low cycles", pcnt, TMO);
        if (cur_rel == 255)
            chk(rx_bits == 0 && tail_edges == 0, "R2 no clock before init high", rx_bits, 0);
        if (cur_crc != 15)
            chk(src_idx == cur_crc, "R5 bytes accepted", src_idx, cur_crc);
        chk(prog_falls == 1, restart ? "R8 single program pulse" : "R1 single program pulse",
            prog_falls, 1);
        src_on = 1'b0;
        drive_src();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (5) tick();
        rst = 1'b0;
        tick();
        chk(prog_n_o == 1'b1, "R9 prog_n", int'(prog_n_o), 1);
        chk(cclk_o == 1'b1, "R9 cclk", int'(cclk_o), 1);
        chk(busy_o == 1'b0, "R9 busy", int'(busy_o), 0);
        chk(fin_o == 1'b0, "R9 fin", int'(fin_o), 0);
        chk(in_ready_o == 1'b0, "R9 ready", int'(in_ready_o), 0);
        chk(status_o == 2'b00, "R9 status", int'(status_o), 0);
        for (int s = 0; s < NSC; s++) run_scen(s, 1'b0);
        // start pulse during a full load must not restart it
        run_scen(0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule